// File: doc/BRIEF.md
# Keyed-Service Software Watchdog

This block is a software watchdog timer. Software writes a control byte once after reset. The byte turns the timer on, picks an optional tick prescaler and selects one of four timeout lengths. After that first write the byte is frozen until the next reset. While the timer is on, it counts qualified ticks of the `tick` input. Software keeps it from expiring by writing an ordered pair of key bytes to a service address.

If the count reaches the selected terminal value before a valid key pair arrives, the block raises `rst_req`. In the same cycle it sets the `wdog_flag` status flag. `rst_req` stays high until a system reset (`rst_n`). The flag survives system resets and is cleared only by the power-on reset (`por_n`). The block has no streaming data path. The register bus is a single-cycle write strobe with no back-pressure, so every write is taken in the cycle it is presented. All control and status pins are plain levels.

Timing parameters: `PRE_LOG2` (prescale divide, default 9), `TMO_BASE_LOG2` (shortest timeout, default 9) and `TMO_STEP_LOG2` (step between timeout choices, default 2).

Top module: `keyed_wdog`

## Requirements
- R1: While `por_n` or `rst_n` is low, `rst_req` is 0. After `por_n` has been low, `wdog_flag` is 0.
- R2: The control byte is written at address `CFG_ADDR` (default 0x1). Its fields are: bit 7 enable; bit 6 prescale select; bits 5:4 timeout select `s`. Bits 3:0 are accepted but have no effect on timing.
- R3: Only the first control write after a reset is taken. Every later control write is ignored until `rst_n` or `por_n` goes low.
- R4: With the timer enabled, the 2^(TMO_BASE_LOG2 + TMO_STEP_LOG2*s)-th qualified tick since the last restart raises `rst_req` and sets `wdog_flag` at that clock edge. With defaults, the terminal counts are 2^9, 2^11, 2^13 and 2^15.
- R5: Writing 0x55 and then 0xAA to address `SVC_ADDR` (default 0x3) services the timer. At the edge of the 0xAA write, the count and prescaler restart from zero, and a tick on that edge is not counted. Repeated 0x55 writes and writes to other addresses between the two key bytes do not break the sequence.
- R6: A 0xAA write with no armed 0x55 before it does not restart the count.
- R7: Writing any value other than 0x55 or 0xAA to `SVC_ADDR` cancels a pending 0x55. A later 0xAA then does not restart the count.
- R8: With the enable bit clear, the timer does not count and `rst_req` never rises.
- R9: With the prescale bit set, one qualified tick is produced per 2^PRE_LOG2 cycles with `tick` high. With the bit clear, every cycle with `tick` high is a qualified tick.
- R10: Once high, `rst_req` stays high and counting stops until `rst_n` goes low.
- R11: `wdog_flag` is held through a system reset and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | 8 | Register write data byte |
| tick | input | 1 | Timebase tick, one per cycle when high |
| rst_req | output | 1 | Sticky reset request on timeout |
| wdog_flag | output | 1 | Watchdog-caused reset status flag |

## Verification
A wrong internal state shows at the ports in only one way: `rst_req` and `wdog_flag` rise in a different cycle than expected. A dropped or stale key arm moves the expiry by up to a full timeout period. A stale count or prescaler shifts the expiry by a fraction of one. A lock that fails to hold can hide the expiry altogether. The bench keeps a behavioural model and compares both outputs on every clock, so a fault is reported at the first edge where the request should, or should not, have risen.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Control byte layout: bit 7 enable, bit 6 prescale, bits 5:4 timeout select
  typedef struct packed {
    logic       en;
    logic       pre_sel;
    logic [1:0] tmo_sel;
  } wd_cfg_t;
endpackage

// File: rtl/kwd_cfg_lock.sv
`timescale 1ns/1ps
module kwd_cfg_lock
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output wd_cfg_t           cfg_o
);
  logic    locked_q;
  wd_cfg_t cfg_q;
  logic    hit;
  logic    unused_spare;

  assign hit          = wr && (addr == CFG_ADDR);
  assign unused_spare = ^wdata[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= '0;
    end else if (hit && !locked_q) begin
      locked_q <= 1'b1;
      cfg_q    <= wd_cfg_t'(wdata[7:4]);
    end
  end

  assign cfg_o = cfg_q;

  a_r3_frozen_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q))
    else $error("R3: control changed after lock");

  a_r3_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> locked_q)
    else $error("R3: control write did not lock");
endmodule

// File: rtl/kwd_key_seq.sv
`timescale 1ns/1ps
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              svc_o
);
  logic armed_q;
  logic hit;

  assign hit   = wr && (addr == SVC_ADDR);
  assign svc_o = hit && armed_q && (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (hit) armed_q <= (wdata == KEY_ARM);
  end

  a_r7_junk_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata != KEY_ARM && wdata != KEY_FIRE) |=> !armed_q)
    else $error("R7: stray value left sequence armed");

  a_r6_fire_consumes_arm: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !armed_q)
    else $error("R6: arm not consumed by service");

  a_r5_arm_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata == KEY_ARM) |=> armed_q)
    else $error("R5: first key did not arm");
endmodule

// File: rtl/kwd_timer.sv
`timescale 1ns/1ps
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int PRE_LOG2      = 9,
  parameter int TMO_BASE_LOG2 = 9,
  parameter int TMO_STEP_LOG2 = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wd_cfg_t cfg,
  input  logic    tick,
  input  logic    svc,
  input  logic    halt,
  output logic    expire_o
);
  localparam int CNT_W = TMO_BASE_LOG2 + 3 * TMO_STEP_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             qual;
  logic             run;

  assign run = cfg.en && !svc && !halt && tick;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      assign qual = !cfg.pre_sel || (pre_q == '1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (!cfg.en || svc)   pre_q <= '0;
        else if (run && cfg.pre_sel) pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign qual = 1'b1;
    end
  endgenerate

  always_comb begin
    last_val = (CNT_W'(1) << (TMO_BASE_LOG2 + TMO_STEP_LOG2 * int'(cfg.tmo_sel)))
               - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!cfg.en || svc) cnt_q <= '0;
    else if (run && qual)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run && qual && (cnt_q == last_val);

  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> (cnt_q == '0))
    else $error("R8: counter moved while disabled");

  a_r5_restart_on_service: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt_q == '0))
    else $error("R5: service did not restart count");

  a_r10_frozen_on_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !svc && cfg.en && $stable(cfg)) |=> $stable(cnt_q))
    else $error("R10: counter moved after request");
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 1,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 3,
  parameter int PRE_LOG2      = 9,
  parameter int TMO_BASE_LOG2 = 9,
  parameter int TMO_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              tick,
  output logic              rst_req,
  output logic              wdog_flag
);
  logic    rst_all_n;
  wd_cfg_t cfg;
  logic    svc;
  logic    expire;
  logic    req_q;
  logic    flag_q;

  assign rst_all_n = rst_n && por_n;

  kwd_cfg_lock #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_all_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg_o(cfg));

  kwd_key_seq #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst_n(rst_all_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .svc_o(svc));

  kwd_timer #(.PRE_LOG2(PRE_LOG2), .TMO_BASE_LOG2(TMO_BASE_LOG2),
              .TMO_STEP_LOG2(TMO_STEP_LOG2)) u_tmr (
    .clk(clk), .rst_n(rst_all_n), .cfg(cfg), .tick(tick), .svc(svc),
    .halt(req_q), .expire_o(expire));

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n)  req_q <= 1'b0;
    else if (expire) req_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
  end

  assign rst_req   = req_q;
  assign wdog_flag = flag_q;

  a_r4_expire_sets_both: assert property (@(posedge clk) disable iff (!rst_all_n)
    expire |=> (req_q && flag_q))
    else $error("R4: expiry did not raise request and flag");

  a_r10_req_sticky: assert property (@(posedge clk) disable iff (!rst_all_n)
    req_q |=> req_q)
    else $error("R10: request dropped without reset");

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    flag_q |=> flag_q)
    else $error("R11: flag dropped without power-on reset");

  a_r1_req_implies_flag: assert property (@(posedge clk) disable iff (!rst_all_n)
    req_q |-> flag_q)
    else $error("R1: request without flag");
endmodule

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  localparam int AW = 4, PL = 2, BL = 3, SL = 2;
  localparam logic [3:0] CA = 4'h1, SA = 4'h3;

  logic clk = 0, rst_n = 0, por_n = 0, bus_wr = 0, tick = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic rst_req, wdog_flag;

  int checks = 0, errors = 0, cyc = 0, el = 0, t0 = 0;
  bit cmp_on = 0, done = 0;

  always #2.5 clk = ~clk;

  keyed_wdog #(.ADDR_W(AW), .CFG_ADDR(CA), .SVC_ADDR(SA), .PRE_LOG2(PL),
               .TMO_BASE_LOG2(BL), .TMO_STEP_LOG2(SL)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick(tick),
    .rst_req(rst_req), .wdog_flag(wdog_flag));

  always @(posedge clk) cyc = cyc + 1;

  // Behavioural reference model
  int m_lock, m_en, m_psel, m_tsel, m_arm, m_pre, m_cnt, m_req, m_flag;
  always @(posedge clk or negedge rst_n or negedge por_n) begin
    int  lim;
    bit  svc, q;
    if (!por_n) begin
      m_lock = 0; m_en = 0; m_psel = 0; m_tsel = 0; m_arm = 0;
      m_pre = 0; m_cnt = 0; m_req = 0; m_flag = 0;
    end else if (!rst_n) begin
      m_lock = 0; m_en = 0; m_psel = 0; m_tsel = 0; m_arm = 0;
      m_pre = 0; m_cnt = 0; m_req = 0;
    end else begin
      svc = bus_wr && bus_addr == SA && bus_wdata == 8'hAA && m_arm != 0;
      lim = 1 << (BL + SL * m_tsel);
      if (m_en != 0) begin
        if (svc) begin
          m_cnt = 0; m_pre = 0;
        end else if (m_req == 0 && tick) begin
          q = (m_psel == 0) || (m_pre == (1 << PL) - 1);
          if (m_psel != 0) m_pre = (m_pre + 1) % (1 << PL);
          if (q) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == lim) begin m_req = 1; m_flag = 1; end
          end
        end
      end else begin
        m_cnt = 0; m_pre = 0;
      end
      if (bus_wr && bus_addr == SA) m_arm = (bus_wdata == 8'h55) ? 1 : 0;
      if (bus_wr && bus_addr == CA && m_lock == 0) begin
        m_lock = 1; m_en = bus_wdata[7]; m_psel = bus_wdata[6];
        m_tsel = int'(bus_wdata[5:4]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rst_req === m_req[0], "model rst_req (R4 R10)", int'(rst_req), m_req);
      chk(wdog_flag === m_flag[0], "model wdog_flag (R4 R11)", int'(wdog_flag), m_flag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog timer expired in bench");
    finish_run();
  end

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sys_reset();
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic pwr_reset();
    @(posedge clk); #1 por_n = 0;
    @(posedge clk); #1 por_n = 1;
  endtask

  task automatic wait_req(input int start, output int elapsed);
    int n = 0;
    while (!rst_req && n < 5000) begin
      @(posedge clk); #1; n = n + 1;
    end
    elapsed = cyc - start;
  endtask

  task automatic timed_case(input logic [7:0] cfgv, input int exp, input string tag);
    sys_reset();
    bus_write(CA, cfgv); t0 = cyc;
    wait_req(t0, el);
    chk(el == exp, tag, el, exp);
  endtask

  initial begin
    idle(2);
    por_n = 1; rst_n = 1;
    cmp_on = 1;
    idle(1);
    // R1: reset state
    chk(rst_req == 0, "R1 rst_req after reset", int'(rst_req), 0);
    chk(wdog_flag == 0, "R1 flag after power-on", int'(wdog_flag), 0);

    // R8: never configured, then configured disabled
    tick = 1;
    idle(600);
    chk(rst_req == 0, "R8 unconfigured no timeout", int'(rst_req), 0);
    bus_write(CA, 8'h30);
    idle(600);
    chk(rst_req == 0, "R8 disabled no timeout", int'(rst_req), 0);

    // R3 + R4: first write wins, later disable ignored
    sys_reset();
    bus_write(CA, 8'h80); t0 = cyc;
    bus_write(CA, 8'h00);
    wait_req(t0, el);
    chk(el == 8, "R3 later control write ignored", el, 8);
    chk(wdog_flag == 1, "R4 flag set on timeout", int'(wdog_flag), 1);

    // R10: sticky request
    idle(20);
    chk(rst_req == 1, "R10 request sticky", int'(rst_req), 1);
    sys_reset();
    chk(rst_req == 0, "R10 request cleared by system reset", int'(rst_req), 0);
    chk(wdog_flag == 1, "R11 flag survives system reset", int'(wdog_flag), 1);

    // R5: ordered key with repeat arm and foreign write
    sys_reset();
    bus_write(CA, 8'h90);
    idle(4);
    bus_write(SA, 8'h55);
    bus_write(CA, 8'h00);
    bus_write(SA, 8'h55);
    bus_write(SA, 8'hAA); t0 = cyc;
    wait_req(t0, el);
    chk(el == 32, "R5 service restarts count", el, 32);

    // R6: lone 0xAA
    sys_reset();
    bus_write(CA, 8'h80); t0 = cyc;
    bus_write(SA, 8'hAA);
    wait_req(t0, el);
    chk(el == 8, "R6 lone fire key ignored", el, 8);

    // R7: stray value cancels arm
    sys_reset();
    bus_write(CA, 8'h90); t0 = cyc;
    bus_write(SA, 8'h55);
    bus_write(SA, 8'h12);
    bus_write(SA, 8'hAA);
    wait_req(t0, el);
    chk(el == 32, "R7 stray value cancels arm", el, 32);

    // R2 / R4: timeout selects and spare bits
    timed_case(8'h8F, 8, "R2 spare bits no effect");
    timed_case(8'hA0, 128, "R4 timeout select 2");
    timed_case(8'hB0, 512, "R4 timeout select 3");
    // R9: prescale
    timed_case(8'hC0, 32, "R9 prescale divides ticks");

    // R9 / R5 / R7: irregular ticks and key traffic, model compared
    sys_reset();
    bus_write(CA, 8'hD0);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      tick = $urandom_range(0, 1) == 1;
      bus_wr = $urandom_range(0, 5) == 0;
      bus_addr = ($urandom_range(0, 3) == 0) ? CA : SA;
      case ($urandom_range(0, 3))
        0, 1: bus_wdata = 8'h55;
        2: bus_wdata = 8'hAA;
        default: bus_wdata = 8'h3C;
      endcase
    end
    bus_wr = 0; tick = 1;
    idle(5);

    // R11: power-on reset clears flag
    bus_write(CA, 8'h80);
    sys_reset();
    bus_write(CA, 8'h80); t0 = cyc;
    wait_req(t0, el);
    chk(wdog_flag == 1, "R11 flag set before power-on reset", int'(wdog_flag), 1);
    pwr_reset();
    chk(wdog_flag == 0, "R11 flag cleared by power-on reset", int'(wdog_flag), 0);
    chk(rst_req == 0, "R1 request cleared by power-on reset", int'(rst_req), 0);
    idle(3);
    finish_run();
  end
endmodule